// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a serial-peripheral master that moves one word of `W` bits out on its serial data output while collecting one word of the same length from its serial data input. It runs entirely on the system clock. The serial clock is made by a divider whose half period is a programmable number of system clocks. Clock idle level, clock phase and bit order are chosen by three plain configuration inputs. All configuration is captured when a word is accepted, so later changes only affect the next transfer.

Transmit words enter through a valid/ready stream port. `tx_ready` is high only while no transfer is running. A word is taken in the cycle where `tx_valid` and `tx_ready` are both high. While the shifter is busy, `tx_ready` stays low and back-pressure holds off the producer. The received word leaves through a valid-only port that has no back-pressure. `rx_valid` pulses for one cycle, and `rx_data` keeps its value until the next transfer completes, so a consumer that misses the pulse can still read the word.

The first data bit is placed on the line a fixed, mode-dependent number of system clocks before the first serial clock edge. The final bit stays on the line after the transfer ends.

Top module: `spi_mst`

## Requirements
- R1: `tx_ready` is high exactly when the block is idle. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `busy` rises on that edge. While `busy` is high, `tx_valid` and `tx_data` have no effect on `sclk`, `simo` or the received word.
- R2: The serial clock half period is H system clocks. H is `cfg_half` clamped to the range 4 to 128, so the full period lies between 8 and 256 system clocks.
- R3: When no transfer is running, `sclk` rests at the level of `cfg_cpol`. It follows that input one cycle later.
- R4: The edges are numbered 1 to 2W from the start of the transfer. With `cfg_cpha`=0, odd edges sample `somi`, and even edges other than the last drive the next bit. With `cfg_cpha`=1, even edges sample, and odd edges other than edge 1 drive. `simo` changes only on a drive edge or when a word is accepted.
- R5: With phase 0, the first bit appears on `simo` in the cycle `busy` rises. The first `sclk` edge follows exactly H system clocks later, which is at least 2.
- R6: With phase 1, the first `sclk` edge follows exactly 2H system clocks after the first bit appears, which is at least H + 2.
- R7: With `cfg_lsb_first`=0, bit W-1 is sent first. With `cfg_lsb_first`=1, bit 0 is sent first. The k-th bit received is stored at the position the k-th bit sent came from, so a slave that returns a word in the same order yields exactly that word on `rx_data`.
- R8: After the last edge, `simo` keeps the final transmitted bit until the next word is accepted.
- R9: `rx_valid` is high for exactly one cycle. That cycle is the one in which the last `sclk` edge appears and `busy` falls. `rx_data` holds its value until the next completion.
- R10: Each transfer produces exactly 2W `sclk` transitions and ends with `sclk` back at its idle level.
- R11: The polarity, phase, bit order and divider are captured at acceptance. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_half | input | DIV_W | Requested half period in system clocks (clamped 4..128) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can accept a word |
| tx_data | input | W | Transmit word |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_data | output | W | Last received word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| simo | output | 1 | Serial data to slave |
| somi | input | 1 | Serial data from slave |

## Verification
The bound checker enforces several rules on every cycle. An accepted word must raise `busy`, and the idle clock level must track polarity. No half period may be shorter than four system clocks. `simo` may move only together with an `sclk` transition while busy, and must stay still while idle. The done pulse must last one cycle and close the transfer. The bench scenarios are needed for the rest: the exact lead of the first bit in each phase, the clamped half period, the edge count, the bit order of both words, and the immunity to writes and configuration changes during a transfer. For these, a behavioural slave runs in all four modes and both orders, and a cycle model is compared on every clock.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;

  typedef enum logic [1:0] {
    EDGE_NONE   = 2'd0,
    EDGE_SAMPLE = 2'd1,
    EDGE_DRIVE  = 2'd2,
    EDGE_QUIET  = 2'd3
  } edge_kind_t;

endpackage

// File: rtl/spi_mst_bitrev.sv
module spi_mst_bitrev #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = en ? din[W-1-i] : din[i];
  end
endmodule

// File: rtl/spi_mst_divider.sv
module spi_mst_divider #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             cpha,
  input  logic [DIV_W-1:0] half_req,
  output logic             tick
);
  localparam int CNT_W = $clog2(2 * MAX_HALF);

  logic [CNT_W-1:0] half_clamp;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lead_m1;

  always_comb begin
    if (half_req < DIV_W'(MIN_HALF))      half_clamp = CNT_W'(MIN_HALF);
    else if (half_req > DIV_W'(MAX_HALF)) half_clamp = CNT_W'(MAX_HALF);
    else                                  half_clamp = CNT_W'(half_req);
  end

  // phase 1 waits a whole period, phase 0 a half period
  always_comb begin
    if (cpha) lead_m1 = ({1'b0, half_clamp} << 1) - (CNT_W+1)'(1);
    else      lead_m1 = {1'b0, half_clamp} - (CNT_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      cnt    <= '0;
    end else if (start) begin
      half_q <= half_clamp;
      cnt    <= lead_m1[CNT_W-1:0];
    end else if (run) begin
      cnt <= (cnt == '0) ? half_q - CNT_W'(1) : cnt - CNT_W'(1);
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_mst_edge_seq.sv
module spi_mst_edge_seq
  import spi_mst_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic       cpha,
  output edge_kind_t kind,
  output logic       last
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic [EC_W-1:0] ecnt;
  logic [EC_W-1:0] enext;
  logic            is_sample;

  assign enext     = ecnt + EC_W'(1);
  assign is_sample = enext[0] ^ cpha;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ecnt <= '0;
    else if (start) ecnt <= '0;
    else if (tick)  ecnt <= enext;
  end

  always_comb begin
    kind = EDGE_NONE;
    if (tick) begin
      if (is_sample)                                            kind = EDGE_SAMPLE;
      else if (enext != EC_W'(1) && enext != EC_W'(EDGES))      kind = EDGE_DRIVE;
      else                                                      kind = EDGE_QUIET;
    end
  end

  assign last = tick && (enext == EC_W'(EDGES));
endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         drive,
  input  logic         sample,
  input  logic         somi,
  output logic         simo,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_sh;
  logic [W-1:0] rx_sh;

  assign rx_next = sample ? {rx_sh[W-2:0], somi} : rx_sh;
  assign simo    = tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (load) begin
      tx_sh <= load_word;
      rx_sh <= '0;
    end else begin
      if (drive) tx_sh <= {tx_sh[W-2:0], 1'b0};
      rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/spi_mst.sv
module spi_mst
  import spi_mst_pkg::*;
#(
  parameter int W        = 16,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             busy,
  output logic             sclk,
  output logic             simo,
  input  logic             somi
);
  spi_mode_t    mode_q;
  logic         busy_q;
  logic         sclk_q;
  logic         rx_valid_q;
  logic [W-1:0] rx_data_q;
  logic         accept;
  logic         tick;
  logic         last;
  edge_kind_t   kind;
  logic [W-1:0] tx_ordered;
  logic [W-1:0] rx_next;
  logic [W-1:0] rx_final;

  assign accept = tx_valid && !busy_q;

  spi_mst_bitrev #(.W(W)) u_tx_order (
    .en(cfg_lsb_first), .din(tx_data), .dout(tx_ordered)
  );

  spi_mst_bitrev #(.W(W)) u_rx_order (
    .en(mode_q.lsb_first), .din(rx_next), .dout(rx_final)
  );

  spi_mst_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .cpha(cfg_cpha), .half_req(cfg_half), .tick(tick)
  );

  spi_mst_edge_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick),
    .cpha(mode_q.cpha), .kind(kind), .last(last)
  );

  spi_mst_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(tx_ordered),
    .drive(kind == EDGE_DRIVE), .sample(kind == EDGE_SAMPLE),
    .somi(somi), .simo(simo), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      busy_q     <= 1'b0;
      sclk_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
        sclk_q <= cfg_cpol;
      end else if (busy_q) begin
        if (last) begin
          sclk_q     <= mode_q.cpol;
          busy_q     <= 1'b0;
          rx_valid_q <= 1'b1;
          rx_data_q  <= rx_final;
        end else if (tick) begin
          sclk_q <= ~sclk_q;
        end
      end else begin
        sclk_q <= cfg_cpol;
      end
    end
  end

  assign tx_ready = !busy_q;
  assign busy     = busy_q;
  assign sclk     = sclk_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
endmodule

// File: rtl/spi_mst_chk.sv
module spi_mst_chk #(
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic sclk,
  input logic simo,
  input logic rx_valid
);
  localparam int GAP_W = $clog2(2 * MAX_HALF + 2);

  logic             past_ok;
  logic             sclk_d;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      sclk_d  <= 1'b0;
      gap     <= '0;
    end else begin
      past_ok <= 1'b1;
      sclk_d  <= sclk;
      if (sclk != sclk_d)   gap <= GAP_W'(1);
      else if (gap != '1)   gap <= gap + GAP_W'(1);
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);

  // R2: no half period shorter than the minimum, counted from the checker's own view
  p_half_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (sclk != sclk_d) && $past(busy)) |-> (gap >= GAP_W'(MIN_HALF)));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy && !$past(busy)) |-> (sclk == $past(cfg_cpol)));

  p_simo_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy) && (sclk == $past(sclk))) |-> $stable(simo));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy) |-> $stable(simo));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rx_valid) |-> (!busy && $past(busy)));
endmodule

bind spi_mst spi_mst_chk #(.MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .busy(busy), .sclk(sclk), .simo(simo), .rx_valid(rx_valid)
);

// File: tb/spi_mst_tb.sv
`timescale 1ns/1ps
module spi_mst_tb;
  localparam int W     = 16;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [DIV_W-1:0] cfg_half = 8'd4;
  logic tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic somi = 1'b0;
  logic tx_ready, rx_valid, busy, sclk, simo;
  logic [W-1:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_mst #(.W(W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_half(cfg_half), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .sclk(sclk), .simo(simo), .somi(somi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp_half(input int d);
    return (d < 4) ? 4 : ((d > 128) ? 128 : d);
  endfunction

  function automatic logic seq_bit(input logic [W-1:0] w, input int k, input bit lsb);
    return lsb ? w[k] : w[W-1-k];
  endfunction

  // ---------------- cycle reference model ----------------
  bit m_busy, m_sclk, m_simo, m_rxv, mcpol, mcpha, mlsb;
  logic [W-1:0] m_rx, mrx, mw;
  int mh, mcnt, mnext, me, mbit, ms;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 0; m_simo = 0; m_rxv = 0; m_rx = '0;
    end else begin
      m_rxv = 0;
      if (m_busy) begin
        mcnt++;
        if (mcnt == mnext) begin
          me++; mnext += mh; m_sclk = !m_sclk;
          if ((me % 2 == 1) != mcpha) begin
            mrx[mlsb ? ms : W-1-ms] = somi; ms++;
          end else if (me != 1 && me != 2*W) begin
            mbit++; m_simo = seq_bit(mw, mbit, mlsb);
          end
          if (me == 2*W) begin m_busy = 0; m_rxv = 1; m_rx = mrx; end
        end
      end else if (tx_valid) begin
        m_busy = 1; mcpol = cfg_cpol; mcpha = cfg_cpha; mlsb = cfg_lsb_first;
        mw = tx_data; mh = clamp_half(int'(cfg_half));
        mnext = mcpha ? 2*mh : mh; mcnt = 0; me = 0; mbit = 0; ms = 0; mrx = '0;
        m_sclk = cfg_cpol; m_simo = seq_bit(tx_data, 0, cfg_lsb_first);
      end else begin
        m_sclk = cfg_cpol;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sclk == m_sclk, "R4", "sclk vs model", sclk, m_sclk);
      chk(simo == m_simo, "R7", "simo vs model", simo, m_simo);
      chk(busy == m_busy, "R1", "busy vs model", busy, m_busy);
      chk(tx_ready == !m_busy, "R1", "tx_ready vs model", tx_ready, !m_busy);
      chk(rx_valid == m_rxv, "R9", "rx_valid vs model", rx_valid, m_rxv);
      if (m_rxv) chk(rx_data == m_rx, "R7", "rx_data vs model", rx_data, m_rx);
    end
  end

  // ---------------- one transfer with a behavioural slave ----------------
  task automatic xfer(input logic [W-1:0] word, input logic [W-1:0] sword,
                      input bit pol, input bit pha, input bit lsb, input int div,
                      input bit poke, input bit flip, input string tag);
    int h, c, first_t, toggles, gmin, gmax, last_t, sj, e, gap;
    logic prev;
    h = clamp_half(div);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_half = DIV_W'(div);
    @(negedge clk);
    chk(sclk == pol, "R3", "idle level before start", sclk, pol);
    tx_data = word; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
    chk(simo == seq_bit(word, 0, lsb), "R7", "first bit", simo, seq_bit(word, 0, lsb));
    prev = sclk; c = 0; first_t = -1; toggles = 0; gmin = 100000; gmax = 0;
    last_t = 0; sj = 0; e = 0;
    if (!pha) begin somi = seq_bit(sword, 0, lsb); sj = 1; end
    while (1) begin
      @(negedge clk); c++;
      if (poke && c == 3) begin tx_valid = 1'b1; tx_data = ~word; end
      if (poke && c == 9) tx_valid = 1'b0;
      if (flip && c == 3) begin
        cfg_cpol = !pol; cfg_cpha = !pha; cfg_lsb_first = !lsb; cfg_half = 8'd5;
      end
      if (sclk !== prev) begin
        toggles++; e++;
        if (first_t < 0) first_t = c;
        else begin
          gap = c - last_t;
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
        end
        last_t = c; prev = sclk;
        if (((e % 2 == 0) != pha) && sj < W) begin
          somi = seq_bit(sword, sj, lsb); sj++;
        end
      end
      if (rx_valid || c > 40000) break;
    end
    if (pha) chk(first_t == 2*h, (tag == "") ? "R6" : tag, "phase1 lead", first_t, 2*h);
    else     chk(first_t == h,   (tag == "") ? "R5" : tag, "phase0 lead", first_t, h);
    chk(gmin == h && gmax == h, (tag == "") ? "R2" : tag, "half period", gmin, h);
    chk(toggles == 2*W, "R10", "edge count", toggles, 2*W);
    chk(sclk == pol, "R10", "clock back at idle", sclk, pol);
    chk(rx_data == sword, (tag == "") ? "R7" : tag, "received word", rx_data, sword);
    chk(!busy, "R9", "busy low at done", busy, 0);
    @(negedge clk);
    chk(!rx_valid, "R9", "done pulse one cycle", rx_valid, 0);
    repeat (10) @(negedge clk);
    chk(simo == seq_bit(word, W-1, lsb), "R8", "final bit held", simo, seq_bit(word, W-1, lsb));
    chk(rx_data == sword, "R9", "rx_data held", rx_data, sword);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R1", "reset ready", tx_ready, 1);
    chk(sclk == 1'b0, "R3", "reset sclk", sclk, 0);
    chk(simo == 1'b0 && !rx_valid && !busy, "R9", "reset outputs", {simo, rx_valid, busy}, 0);
    // R3: idle level follows polarity
    cfg_cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R3", "idle follows cpol", sclk, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    // R4 R7: all modes, both orders
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        xfer(16'hA5C3 ^ 16'(m * 257 + l), 16'h3C5A + 16'(m * 17 + l),
             m[1], m[0], l[0], 4 + m, 1'b0, 1'b0, "");
      end
    end
    // R2: clamping at both ends
    xfer(16'h8001, 16'h7FFE, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R2");
    xfer(16'h1234, 16'hFEDC, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R2");
    xfer(16'h0F0F, 16'hF0F1, 1'b0, 1'b1, 1'b1, 200, 1'b0, 1'b0, "R2");
    // R1: writes while busy are ignored
    xfer(16'hC0DE, 16'h5A5A, 1'b0, 1'b0, 1'b0, 4, 1'b1, 1'b0, "R1");
    // R11: configuration changes during a transfer have no effect
    xfer(16'hBEEF, 16'h1357, 1'b1, 1'b0, 1'b1, 6, 1'b0, 1'b1, "R11");
    xfer(16'h0001, 16'h8000, 1'b0, 1'b1, 1'b0, 7, 1'b0, 1'b1, "R11");
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule